// File: doc/BRIEF.md
# Banked Parallel EEPROM Write and Poll Controller

This controller sits between a host and a 16-bit parallel EEPROM array made of four banks of 128K words. The host hands it commands one at a time over a valid/ready stream: a single-word read, or a word write that opens or extends a page burst. The controller turns each command into chip-select, write-enable and output-enable strobes. It decodes the two most significant address bits into four active-low bank selects and places the remaining 17 bits on the memory address bus.

Writes are grouped into page bursts. The memory commits a whole page in one internal programming cycle, so every further word of the burst must arrive before the memory's load window closes. When the burst ends, the controller reads back the last word it wrote. It repeats that read until the status bit at the top of each byte lane (bits 7 and 15) matches the written data. At that point it pulses `done`. If the match does not come within the programming time limit, it pulses `err` instead. All timings are parameters counted in clock cycles, so the integrator rounds the nanosecond or microsecond figures up at the target clock rate.

Back-pressure on the command stream: a command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. The host holds the payload steady while `cmd_valid` is high and `cmd_ready` is low. While the load window of an open burst is running, `cmd_ready` depends on the offered payload: it is high only for a write to the same page. On the response stream, `rsp_valid` and `rsp_data` stay fixed until `rsp_ready` is seen high.

Top module: `eep_bank_ctrl`

## Requirements
- R1: `mem_cs_n[b]` is driven low only for accesses whose address bits [18:17] equal b. No more than one bank select is ever low at a time, and all of them are high when no access is in progress.
- R2: For each written word, the bank select is low and `mem_wdata_oe` is high for exactly T_AS cycles before `mem_we_n` falls. `mem_we_n` then stays low for max(T_WP, T_DS) cycles while `mem_wdata` is held stable. `mem_oe_n` is high whenever `mem_we_n` is low.
- R3: Between two write-enable pulses, `mem_we_n` stays high for at least T_WPH cycles.
- R4: After each word's high time, a window of T_WIN cycles opens. During it, a write whose address bits [18:PAGE_W] match the open page is accepted and extends the burst. While `busy` is high, any read or other-page write is held off with `cmd_ready` low, and every word of a burst uses the same page bits.
- R5: A burst ends after a word flagged with `cmd_last`, after its 2^PAGE_W-th word, or when the window passes with no continuation. Completion polling then starts, and no further word is accepted.
- R6: Each poll read drives the last written address with the bank select and `mem_oe_n` low for T_RD cycles. On a mismatch of bit 7 or bit 15, `mem_oe_n` returns high for T_GAP cycles before the next poll read.
- R7: When a poll read returns bits 7 and 15 equal to the written word, `done` pulses for one cycle and `busy` is low in that same cycle. `done` and `err` are never high together.
- R8: If polling has not matched within T_WC cycles of its start, `err` pulses for one cycle, `busy` falls, and `done` does not pulse for that burst.
- R9: A read command holds the bank select and `mem_oe_n` low for T_RD cycles. The data present at the end of that time appears on `rsp_data` with `rsp_valid`, and both hold until `rsp_ready` is high.
- R10: `busy` rises with the first accepted word of a burst and stays high until the cycle of `done` or `err`. `mem_we_n` is low only while `busy` is high.
- R11: After reset, `cmd_ready` is 1. `busy`, `done`, `err` and `rsp_valid` are 0. All bank selects, `mem_we_n` and `mem_oe_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_write | input | 1 | 1 = word write, 0 = word read |
| cmd_last | input | 1 | This write closes the burst |
| cmd_addr | input | 19 | Word address; [18:17] select the bank |
| cmd_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Host takes the read data |
| rsp_data | output | 16 | Read data |
| busy | output | 1 | Burst loading or completion polling in progress |
| done | output | 1 | One-cycle pulse: page programmed |
| err | output | 1 | One-cycle pulse: polling timed out |
| mem_addr | output | 17 | Address within a bank |
| mem_cs_n | output | 4 | Active-low bank selects |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_wdata | output | 16 | Data toward the memory |
| mem_wdata_oe | output | 1 | Enable for the data bus driver |
| mem_rdata | input | 16 | Data from the memory |

## Verification
The bench builds the controller with 8-word pages (PAGE_W = 3) and short cycle counts: T_AS 1, T_WP 3, T_DS 2, T_WPH 2, T_RD 2, T_GAP 2, T_WIN 10 and T_WC 60. The word cap and the timeout therefore occur within a few dozen cycles. T_WP is chosen larger than T_DS, so the pulse width has to follow the larger of the two. The bench's memory model starts programming only after its own longer load window has passed. That makes window-expiry bursts, several failing polls before a match, and a programming time beyond T_WC all reachable in one short run.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WSET,
    ST_WLOW,
    ST_WHIGH,
    ST_WWIN,
    ST_PREAD,
    ST_PGAP,
    ST_RREAD,
    ST_RRESP
  } eep_state_t;

endpackage

// File: rtl/eep_bank_dec.sv
module eep_bank_dec #(
  parameter int BANKS = 4,
  localparam int SEL_W = $clog2(BANKS)
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [BANKS-1:0] sel_n
);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign sel_n[b] = !(en && (sel == SEL_W'(b)));
  end

endmodule

// File: rtl/eep_cdown.sv
module eep_cdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/eep_poll_cmp.sv
module eep_poll_cmp #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0] rd_flag,
  input  logic [LANES-1:0] wr_flag,
  output logic             match
);

  logic [LANES-1:0] lane_ok;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_ok[l] = (rd_flag[l] == wr_flag[l]);
  end

  assign match = &lane_ok;

endmodule

// File: rtl/eep_bank_ctrl.sv
module eep_bank_ctrl import eep_pkg::*; #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int BANKS  = 4,
  parameter int PAGE_W = 7,
  parameter int T_AS   = 2,
  parameter int T_WP   = 20,
  parameter int T_DS   = 10,
  parameter int T_WPH  = 10,
  parameter int T_RD   = 30,
  parameter int T_WIN  = 28000,
  parameter int T_GAP  = 4,
  parameter int T_WC   = 2000000,
  localparam int BANK_W = $clog2(BANKS),
  localparam int LOW_AW = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic              cmd_last,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [LOW_AW-1:0] mem_addr,
  output logic [BANKS-1:0]  mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_oe,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int LOW_CYC    = (T_WP > T_DS) ? T_WP : T_DS;
  localparam int PH_M1      = (LOW_CYC > T_WIN) ? LOW_CYC : T_WIN;
  localparam int PH_M2      = (T_RD > T_WPH) ? T_RD : T_WPH;
  localparam int PH_M3      = (T_AS > T_GAP) ? T_AS : T_GAP;
  localparam int PH_M4      = (PH_M1 > PH_M2) ? PH_M1 : PH_M2;
  localparam int PH_MAX     = (PH_M4 > PH_M3) ? PH_M4 : PH_M3;
  localparam int PH_W       = $clog2(PH_MAX + 1);
  localparam int TO_W       = $clog2(T_WC + 1);
  localparam int WC_W       = PAGE_W + 1;
  localparam int PAGE_WORDS = 1 << PAGE_W;
  localparam int LANES      = DATA_W / 8;

  eep_state_t        state_q, state_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic [WC_W-1:0]   wcnt_q, wcnt_n;
  logic              end_q;
  logic              accept, same_page;
  logic              ph_load, ph_zero;
  logic [PH_W-1:0]   ph_val;
  logic              to_load, to_zero;
  logic              done_set, err_set;
  logic              match;
  logic              cs_en;
  logic [BANKS-1:0]  cs_dec_n;
  logic [LANES-1:0]  rd_flag, wr_flag;

  // phase timer: every strobe phase runs for a fixed cycle count
  eep_cdown #(.W(PH_W)) u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .load (ph_load),
    .val  (ph_val),
    .zero (ph_zero)
  );

  // programming time limit, armed once at the start of polling
  eep_cdown #(.W(TO_W)) u_limit (
    .clk  (clk),
    .rst_n(rst_n),
    .load (to_load),
    .val  (TO_W'(T_WC - 1)),
    .zero (to_zero)
  );

  // top bit of each byte lane carries the in-progress status
  for (genvar l = 0; l < LANES; l++) begin : g_flag
    assign rd_flag[l] = mem_rdata[8*l + 7];
    assign wr_flag[l] = data_q[8*l + 7];
  end

  eep_poll_cmp #(.LANES(LANES)) u_cmp (
    .rd_flag(rd_flag),
    .wr_flag(wr_flag),
    .match  (match)
  );

  eep_bank_dec #(.BANKS(BANKS)) u_dec (
    .en   (cs_en),
    .sel  (addr_n[ADDR_W-1 -: BANK_W]),
    .sel_n(cs_dec_n)
  );

  assign same_page = (cmd_addr[ADDR_W-1:PAGE_W] == addr_q[ADDR_W-1:PAGE_W]);

  always_comb begin
    cmd_ready = 1'b0;
    if (state_q == ST_IDLE)      cmd_ready = 1'b1;
    else if (state_q == ST_WWIN) cmd_ready = cmd_write && same_page;
  end

  assign accept = cmd_valid && cmd_ready;
  assign addr_n = accept ? cmd_addr : addr_q;
  assign data_n = (accept && cmd_write) ? cmd_wdata : data_q;
  assign wcnt_n = (state_q == ST_IDLE) ? WC_W'(1) : wcnt_q + 1'b1;

  always_comb begin
    state_n  = state_q;
    ph_load  = 1'b0;
    ph_val   = '0;
    to_load  = 1'b0;
    done_set = 1'b0;
    err_set  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        ph_load = 1'b1;
        if (cmd_write) begin
          state_n = ST_WSET;
          ph_val  = PH_W'(T_AS - 1);
        end else begin
          state_n = ST_RREAD;
          ph_val  = PH_W'(T_RD - 1);
        end
      end
      ST_WSET: if (ph_zero) begin
        state_n = ST_WLOW;
        ph_load = 1'b1;
        ph_val  = PH_W'(LOW_CYC - 1);
      end
      ST_WLOW: if (ph_zero) begin
        state_n = ST_WHIGH;
        ph_load = 1'b1;
        ph_val  = PH_W'(T_WPH - 1);
      end
      ST_WHIGH: if (ph_zero) begin
        ph_load = 1'b1;
        if (end_q) begin
          state_n = ST_PREAD;
          ph_val  = PH_W'(T_RD - 1);
          to_load = 1'b1;
        end else begin
          state_n = ST_WWIN;
          ph_val  = PH_W'(T_WIN - 1);
        end
      end
      ST_WWIN: if (accept) begin
        state_n = ST_WSET;
        ph_load = 1'b1;
        ph_val  = PH_W'(T_AS - 1);
      end else if (ph_zero) begin
        state_n = ST_PREAD;
        ph_load = 1'b1;
        ph_val  = PH_W'(T_RD - 1);
        to_load = 1'b1;
      end
      ST_PREAD: if (ph_zero) begin
        if (match) begin
          state_n  = ST_IDLE;
          done_set = 1'b1;
        end else if (to_zero) begin
          state_n = ST_IDLE;
          err_set = 1'b1;
        end else begin
          state_n = ST_PGAP;
          ph_load = 1'b1;
          ph_val  = PH_W'(T_GAP - 1);
        end
      end
      ST_PGAP: if (ph_zero) begin
        if (to_zero) begin
          state_n = ST_IDLE;
          err_set = 1'b1;
        end else begin
          state_n = ST_PREAD;
          ph_load = 1'b1;
          ph_val  = PH_W'(T_RD - 1);
        end
      end
      ST_RREAD: if (ph_zero) state_n = ST_RRESP;
      ST_RRESP: if (rsp_ready) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  assign cs_en = (state_n == ST_WSET) || (state_n == ST_WLOW) || (state_n == ST_WHIGH) ||
                 (state_n == ST_PREAD) || (state_n == ST_RREAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      wcnt_q  <= '0;
      end_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
      if (accept && cmd_write) begin
        wcnt_q <= wcnt_n;
        end_q  <= cmd_last || (wcnt_n == WC_W'(PAGE_WORDS));
      end
    end
  end

  // memory-side strobes are flops, decoded from the next state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n     <= '1;
      mem_we_n     <= 1'b1;
      mem_oe_n     <= 1'b1;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      mem_wdata_oe <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      err          <= 1'b0;
    end else begin
      mem_cs_n     <= cs_dec_n;
      mem_we_n     <= !(state_n == ST_WLOW);
      mem_oe_n     <= !((state_n == ST_PREAD) || (state_n == ST_RREAD));
      mem_addr     <= addr_n[LOW_AW-1:0];
      mem_wdata    <= data_n;
      mem_wdata_oe <= (state_n == ST_WSET) || (state_n == ST_WLOW) || (state_n == ST_WHIGH);
      busy         <= (state_n != ST_IDLE) && (state_n != ST_RREAD) && (state_n != ST_RRESP);
      done         <= done_set;
      err          <= err_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (state_q == ST_RREAD && ph_zero) begin
      rsp_valid <= 1'b1;
      rsp_data  <= mem_rdata;
    end else if (state_q == ST_RRESP && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/eep_bank_ctrl_chk.sv
module eep_bank_ctrl_chk #(
  parameter int BANKS  = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [BANKS-1:0]  mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_wdata_oe
);

  // R1
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  // R2
  oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_wdata_oe));

  // R2
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_wdata));

  // R4
  ready_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && busy) |-> cmd_write);

  // R7
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R7
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R10
  we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> busy);

endmodule

bind eep_bank_ctrl eep_bank_ctrl_chk #(.BANKS(BANKS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/eep_bank_ctrl_tb.sv
`timescale 1ns/1ps
module eep_bank_ctrl_tb;

  localparam int T_AS = 1, T_WP = 3, T_DS = 2, T_WPH = 2, T_RD = 2;
  localparam int T_WIN = 10, T_GAP = 2, T_WC = 60, PAGE_W = 3;
  localparam int LOW_CYC = 3;
  localparam int MODEL_WIN = 20;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_last = 1'b0;
  logic [18:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        cmd_ready, rsp_valid, busy, done, err;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic [16:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_we_n, mem_oe_n, mem_wdata_oe;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  eep_bank_ctrl #(
    .PAGE_W(PAGE_W), .T_AS(T_AS), .T_WP(T_WP), .T_DS(T_DS), .T_WPH(T_WPH),
    .T_RD(T_RD), .T_WIN(T_WIN), .T_GAP(T_GAP), .T_WC(T_WC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_last(cmd_last), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .busy(busy), .done(done), .err(err),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
    .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_mem [int];
  logic [15:0] rq [$];
  int          evq [$];
  int          cur_bank = 0;
  logic [18:0] last_wa = '0;
  int          prog_len = 15;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bank_of(input logic [3:0] csn);
    int idx = -1;
    for (int b = 0; b < 4; b++) if (!csn[b]) idx = b;
    return idx;
  endfunction

  // memory model: page buffer, load window, programming time
  logic [15:0] mdata [int];
  int          pk [$];
  logic [15:0] pd [$];
  logic [15:0] last_wd = '0;
  bit          pend = 0, prog = 0, m_prev_we = 1;
  int          since_fall = 0, pcnt = 0, first_page = 0;

  always @(negedge clk) begin
    int key;
    if (m_prev_we && !mem_we_n) since_fall = 0;
    else since_fall++;
    if (!m_prev_we && mem_we_n && bank_of(mem_cs_n) >= 0) begin
      key = (bank_of(mem_cs_n) << 17) | int'(mem_addr);
      if (pk.size() == 0) first_page = key >> PAGE_W;
      else chk((key >> PAGE_W) == first_page, "R4 page bits constant in burst", key >> PAGE_W, first_page);
      pk.push_back(key);
      pd.push_back(mem_wdata);
      last_wd = mem_wdata;
      pend = 1;
    end
    m_prev_we = mem_we_n;
    if (pend && !prog && since_fall >= MODEL_WIN) begin
      prog = 1;
      pcnt = 0;
    end
    if (prog) begin
      pcnt++;
      if (pcnt >= prog_len) begin
        while (pk.size() > 0) mdata[pk.pop_front()] = pd.pop_front();
        pd.delete();
        prog = 0;
        pend = 0;
      end
    end
    if (!mem_oe_n && bank_of(mem_cs_n) >= 0) begin
      key = (bank_of(mem_cs_n) << 17) | int'(mem_addr);
      if (pend || prog) mem_rdata = last_wd ^ 16'h8080;
      else mem_rdata = mdata.exists(key) ? mdata[key] : 16'hFFFF;
    end else begin
      mem_rdata = 16'h0000;
    end
  end

  // monitor: strobe timing, bank decode, events and read scoreboard
  bit prev_we = 1, prev_oe = 1;
  int we_run = 0, we_hi_run = 100, cs_run = 0, oe_run = 0;
  always @(negedge clk) begin
    logic [3:0] exp_cs;
    if (rst_n) begin
      exp_cs = ~(4'b0001 << cur_bank);
      chk($countones(~mem_cs_n) <= 1, "R1 at most one bank select low", mem_cs_n, 4'hF);
      if (prev_we && !mem_we_n) begin
        chk(cs_run == T_AS, "R2 select lead before write enable", cs_run, T_AS);
        chk(we_hi_run >= T_WPH, "R3 write enable high time", we_hi_run, T_WPH);
        chk(mem_cs_n == exp_cs, "R1 write bank decode", mem_cs_n, exp_cs);
        we_run = 0;
      end
      if (!prev_we && mem_we_n) begin
        chk(we_run == LOW_CYC, "R2 write enable low width", we_run, LOW_CYC);
        we_hi_run = 0;
      end
      if (!mem_we_n) begin
        if (!(mem_oe_n && mem_wdata_oe))
          chk(0, "R2 output enable high during write", mem_oe_n, 1);
        we_run++;
      end else we_hi_run++;
      if (prev_oe && !mem_oe_n) begin
        chk(mem_cs_n == exp_cs, "R1 read bank decode", mem_cs_n, exp_cs);
        if (busy) chk(mem_addr == last_wa[16:0], "R6 poll reads last written address", mem_addr, last_wa[16:0]);
        oe_run = 0;
      end
      if (!prev_oe && mem_oe_n)
        chk(oe_run == T_RD, "R6 R9 output enable low width", oe_run, T_RD);
      if (!mem_oe_n) oe_run++;
      if (mem_cs_n != 4'hF) cs_run++;
      else cs_run = 0;
      prev_we = mem_we_n;
      prev_oe = mem_oe_n;
      if (done || err) begin
        if (evq.size() == 0) chk(0, "R7 R8 unexpected completion event", {done, err}, 0);
        else chk(evq.pop_front() == (done ? 1 : 2), "R7 R8 completion kind", done ? 1 : 2, 0);
        chk(!busy, "R10 busy low at completion", busy, 0);
      end
      if (rsp_valid && rsp_ready) begin
        if (rq.size() == 0) chk(0, "R9 unexpected read response", rsp_data, 0);
        else begin
          logic [15:0] e;
          e = rq.pop_front();
          chk(rsp_data == e, "R9 read data", rsp_data, e);
        end
      end
    end
  end

  always @(posedge clk) rsp_ready <= ($urandom_range(0, 2) != 0);

  task automatic send(input bit wr, input bit last, input logic [18:0] a, input logic [15:0] d);
    bit taken = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_last = last; cmd_addr = a; cmd_wdata = d;
    while (!taken) begin
      #1;
      if (cmd_ready) taken = 1;
      else @(negedge clk);
    end
    cur_bank = int'(a[18:17]);
    if (wr) begin
      last_wa = a;
      exp_mem[int'(a)] = d;
    end else begin
      rq.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'hFFFF);
    end
    @(posedge clk);
    #1 cmd_valid = 0;
  endtask

  task automatic probe(input bit wr, input logic [18:0] a, input string req);
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_last = 0; cmd_addr = a; cmd_wdata = 16'h0;
    #1;
    chk(cmd_ready == 0, req, cmd_ready, 0);
    cmd_valid = 0;
  endtask

  task automatic wait_quiet(input string req);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while ((evq.size() != 0 || busy || rq.size() != 0) && n < 2000);
    chk(n < 2000, req, n, 2000);
  endtask

  task automatic wait_window();
    do @(negedge clk); while (!(busy && mem_cs_n == 4'hF && mem_oe_n));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cmd_ready == 1, "R11 ready after reset", cmd_ready, 1);
    chk(busy == 0 && done == 0 && err == 0, "R11 status low after reset", {busy, done, err}, 0);
    chk(mem_cs_n == 4'hF && mem_we_n && mem_oe_n, "R11 strobes high after reset",
        {mem_cs_n, mem_we_n, mem_oe_n}, 6'h3F);
    chk(rsp_valid == 0, "R11 no response after reset", rsp_valid, 0);
    rst_n = 1;

    // R2 R7 R10: three-word burst closed by the last flag
    evq.push_back(1);
    send(1, 0, 19'h2_0100, 16'h8001);
    #1 chk(busy == 1, "R10 busy after first word", busy, 1);
    send(1, 0, 19'h2_0101, 16'h1280);
    send(1, 1, 19'h2_0102, 16'h7F7F);
    wait_quiet("R7 burst completes");

    // R4: hold-off during the load window, then continuation
    evq.push_back(1);
    send(1, 0, 19'h4_0208, 16'hA5A5);
    wait_window();
    probe(1, 19'h4_0300, "R4 other-page write held off");
    probe(0, 19'h4_0208, "R4 read held off while busy");
    send(1, 1, 19'h4_020C, 16'h5A5A);
    wait_quiet("R4 continued burst completes");

    // R5: window passes with no continuation
    evq.push_back(1);
    send(1, 0, 19'h0_0010, 16'h0F0F);
    send(1, 0, 19'h0_0011, 16'hF0F0);
    wait_quiet("R5 window expiry completes");

    // R5: page word cap
    evq.push_back(1);
    for (int i = 0; i < 8; i++) send(1, 0, 19'h0_0040 + 19'(i), 16'h1111 * 16'(i + 1));
    for (int i = 0; i < 12; i++) probe(1, 19'h0_0040, "R5 no ninth word after cap");
    chk(busy == 1, "R5 polling after cap", busy, 1);
    wait_quiet("R5 capped burst completes");

    // R8: programming longer than the limit
    prog_len = 200;
    evq.push_back(2);
    send(1, 1, 19'h6_0000, 16'h8888);
    wait_quiet("R8 timeout reported");
    repeat (300) @(negedge clk);
    prog_len = 15;

    // R9 R1: readback through all banks
    send(0, 0, 19'h2_0100, 0);
    send(0, 0, 19'h2_0102, 0);
    send(0, 0, 19'h4_0208, 0);
    send(0, 0, 19'h4_020C, 0);
    send(0, 0, 19'h0_0011, 0);
    send(0, 0, 19'h0_0047, 0);
    send(0, 0, 19'h6_0000, 0);
    send(0, 0, 19'h6_1234, 0);
    wait_quiet("R9 reads drained");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule